// File: doc/BRIEF.md
# ATM Cell Destination Selector with Header Rewrite

This block decides, for every ATM cell taken in on one of three receive ports, which destinations get a copy of the cell. It also produces the cell header that goes out with the cell. A cell whose VPI/VCI was found in the connection table is routed by the table entry that the surrounding logic has already fetched. That entry holds two separate destination masks, one for user cells and one for OAM cells, so the two kinds of cell on the same connection can go to different places. A cell that was not found is routed by a per-port setting, again with one setting for user cells and one for OAM cells.

There are five destinations: transmit ports A, B and C, the data-cell FIFO path, and the segmentation-and-reassembly (SAR) path. Only a known user cell on a connection with no header rewrite can reach the SAR path. In long-entry mode, an entry can ask for any of three header fields to be replaced with values it stores. An entry can also mark its connection as clock-recovery stream A or stream B. The decision is registered and is presented one clock after the input strobe.

Top module: `atm_cell_router`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low in every other cycle, including the whole time reset is held and the first cycle after it.
- R2: For a known user cell (`in_known`=1, `in_oam`=0) with no rewrite, `out_dest` equals `ent_w0[4:0]`. Bit 0 is port A, bit 1 port B, bit 2 port C, bit 3 the data-cell FIFO path and bit 4 the SAR path. All zeros means discard.
- R3: For a known OAM cell, `out_dest` equals {0, `ent_w0[8:5]`}, using the same bit order. The SAR bit is always 0, whatever `ent_w0[4:0]` holds.
- R4: For an unknown cell, `out_dest` is {0, map}. The map is `unk_oam_map` for OAM cells and `unk_norm_map` for user cells, and each holds four bits per port: bits [3:0] for port code 0 (A), [7:4] for code 1 (B) and [11:8] for code 2 (C). Port code 3 discards. An unknown cell is never rewritten and never raises a clock-recovery pulse, whatever the entry words hold.
- R5: With `long_mode`=1 and a known cell, `ent_w0[13]` replaces VPI[11:8] with `ent_w1[11:8]`, `ent_w0[14]` replaces VPI[7:0] with `ent_w1[7:0]`, and `ent_w0[15]` replaces VCI[15:0] with `ent_w2`. Each flag acts on its own field only. `out_xlated` is 1 when any of these flags is set.
- R6: With `long_mode`=0, `ent_w0[15:13]`, `ent_w1` and `ent_w2` have no effect. The output header equals the input header bit for bit, and `out_xlated` is 0.
- R7: A rewritten cell never gets SAR bit 4. The bit is cleared and bits 3:0 of the mask are kept, so the cell is not dropped.
- R8: For a known cell, `out_crv_a` pulses high for one cycle, together with `out_valid`, when `ent_w0[9]`=1, and `out_crv_b` does the same when `ent_w0[10]`=1. Both are low whenever `out_valid` is low.
- R9: A long-mode entry with no replace flag set leaves the header unchanged, whatever `ent_w1` and `ent_w2` contain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Cell decision request strobe |
| in_known | input | 1 | Connection was found in the table |
| in_oam | input | 1 | Cell is an OAM cell |
| in_port | input | 2 | Receive port code: 0=A, 1=B, 2=C |
| in_vpi | input | 12 | Received VPI |
| in_vci | input | 16 | Received VCI |
| ent_w0 | input | 16 | Entry word with masks, tags and replace flags |
| ent_w1 | input | 16 | Entry word with the replacement VPI in [11:0] |
| ent_w2 | input | 16 | Entry word with the replacement VCI |
| long_mode | input | 1 | 1 = long entries, which allow header rewrite |
| unk_norm_map | input | 12 | Per-port map for unknown user cells |
| unk_oam_map | input | 12 | Per-port map for unknown OAM cells |
| out_valid | output | 1 | Decision valid |
| out_dest | output | 5 | Destination mask |
| out_vpi | output | 12 | Outgoing VPI |
| out_vci | output | 16 | Outgoing VCI |
| out_xlated | output | 1 | Header was rewritten |
| out_crv_a | output | 1 | Clock-recovery stream A pulse |
| out_crv_b | output | 1 | Clock-recovery stream B pulse |

## Verification
The same entry word is given once for a user cell and once for an OAM cell, which shows that the two masks are selected separately and that the SAR bit is kept away from OAM cells. Each replace flag is set alone and then all three together, with different replacement values, so a swapped or shared field shows up. The same flags are then given in short mode, where they must be ignored, and in long mode with only garbage in the extra words, where the header must also pass through. Unknown cells on every port code, including the unused code 3, are given entry words that would route, rewrite and tag the cell, so any leak of the entry into the unknown-cell path becomes visible.

// File: rtl/atm_cell_router.sv
module atm_cell_router #(
  parameter int VPI_W = 12,
  parameter int VCI_W = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_known,
  input  logic              in_oam,
  input  logic [1:0]        in_port,
  input  logic [VPI_W-1:0]  in_vpi,
  input  logic [VCI_W-1:0]  in_vci,
  input  logic [WORD_W-1:0] ent_w0,
  input  logic [WORD_W-1:0] ent_w1,
  input  logic [WORD_W-1:0] ent_w2,
  input  logic              long_mode,
  input  logic [11:0]       unk_norm_map,
  input  logic [11:0]       unk_oam_map,
  output logic              out_valid,
  output logic [4:0]        out_dest,
  output logic [VPI_W-1:0]  out_vpi,
  output logic [VCI_W-1:0]  out_vci,
  output logic              out_xlated,
  output logic              out_crv_a,
  output logic              out_crv_b
);
  localparam int LO_W = 8;

  logic rep_hi, rep_lo, rep_vc, xl;
  assign rep_hi = long_mode & in_known & ent_w0[13];
  assign rep_lo = long_mode & in_known & ent_w0[14];
  assign rep_vc = long_mode & in_known & ent_w0[15];
  assign xl     = rep_hi | rep_lo | rep_vc;

  logic [3:0] unk_sel;
  always_comb begin
    case (in_port)
      2'd0:    unk_sel = in_oam ? unk_oam_map[3:0]  : unk_norm_map[3:0];
      2'd1:    unk_sel = in_oam ? unk_oam_map[7:4]  : unk_norm_map[7:4];
      2'd2:    unk_sel = in_oam ? unk_oam_map[11:8] : unk_norm_map[11:8];
      default: unk_sel = 4'd0;
    endcase
  end

  logic [4:0] dest_n;
  always_comb begin
    if (!in_known)   dest_n = {1'b0, unk_sel};
    else if (in_oam) dest_n = {1'b0, ent_w0[8:5]};
    else             dest_n = {ent_w0[4] & ~xl, ent_w0[3:0]};
  end

  logic [VPI_W-1:0] vpi_n;
  logic [VCI_W-1:0] vci_n;
  assign vpi_n[VPI_W-1:LO_W] = rep_hi ? ent_w1[VPI_W-1:LO_W] : in_vpi[VPI_W-1:LO_W];
  assign vpi_n[LO_W-1:0]     = rep_lo ? ent_w1[LO_W-1:0]     : in_vpi[LO_W-1:0];
  assign vci_n               = rep_vc ? ent_w2[VCI_W-1:0]    : in_vci;

  logic unused_bits;
  assign unused_bits = ^{ent_w0[12:11], ent_w1[WORD_W-1:VPI_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_dest   <= '0;
      out_vpi    <= '0;
      out_vci    <= '0;
      out_xlated <= 1'b0;
      out_crv_a  <= 1'b0;
      out_crv_b  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_crv_a <= in_valid & in_known & ent_w0[9];
      out_crv_b <= in_valid & in_known & ent_w0[10];
      if (in_valid) begin
        out_dest   <= dest_n;
        out_vpi    <= vpi_n;
        out_vci    <= vci_n;
        out_xlated <= xl;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r3_oam_no_sar: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_oam) |=> !out_dest[4]);
  a_r4_unknown_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_known) |=> (!out_dest[4] && !out_xlated && !out_crv_a && !out_crv_b
                                  && out_vpi == $past(in_vpi) && out_vci == $past(in_vci)));
  a_r6_short_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !long_mode) |=> (!out_xlated && out_vpi == $past(in_vpi) && out_vci == $past(in_vci)));
  a_r7_xlate_no_sar: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_xlated) |-> !out_dest[4]);
  a_r8_pulse_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_crv_a || out_crv_b) |-> out_valid);
endmodule

// File: tb/test_atm_cell_router.sv
module test_atm_cell_router;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_known = 0, in_oam = 0, long_mode = 0;
  logic [1:0] in_port = 0;
  logic [11:0] in_vpi = 0, unk_norm_map = 0, unk_oam_map = 0;
  logic [15:0] in_vci = 0, ent_w0 = 0, ent_w1 = 0, ent_w2 = 0;
  logic out_valid, out_xlated, out_crv_a, out_crv_b;
  logic [4:0] out_dest;
  logic [11:0] out_vpi;
  logic [15:0] out_vci;

  always #(CLK_P/2) clk = ~clk;

  atm_cell_router i_atm_cell_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_known(in_known), .in_oam(in_oam),
    .in_port(in_port), .in_vpi(in_vpi), .in_vci(in_vci), .ent_w0(ent_w0), .ent_w1(ent_w1),
    .ent_w2(ent_w2), .long_mode(long_mode), .unk_norm_map(unk_norm_map), .unk_oam_map(unk_oam_map),
    .out_valid(out_valid), .out_dest(out_dest), .out_vpi(out_vpi), .out_vci(out_vci),
    .out_xlated(out_xlated), .out_crv_a(out_crv_a), .out_crv_b(out_crv_b));

  typedef struct packed {
    logic [23:0] tag;
    logic [4:0]  dest;
    logic [11:0] vpi;
    logic [15:0] vci;
    logic        xl, a, b;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic exp_t model(logic kn, logic oam, logic [1:0] p, logic [11:0] vpi,
                                 logic [15:0] vci, logic [15:0] w0, logic [15:0] w1,
                                 logic [15:0] w2, logic lm, logic [11:0] un, logic [11:0] uo);
    exp_t e;
    logic [11:0] m;
    e.vpi = vpi; e.vci = vci; e.xl = 0; e.a = 0; e.b = 0; e.tag = "   ";
    if (!kn) begin
      m = oam ? uo : un;
      e.dest = (p == 2'd3) ? 5'd0 : {1'b0, m[p*4 +: 4]};
    end else begin
      if (lm) begin
        if (w0[13]) e.vpi[11:8] = w1[11:8];
        if (w0[14]) e.vpi[7:0] = w1[7:0];
        if (w0[15]) e.vci = w2;
        e.xl = |w0[15:13];
      end
      e.a = w0[9]; e.b = w0[10];
      if (oam) e.dest = {1'b0, w0[8:5]};
      else     e.dest = {w0[4] & ~e.xl, w0[3:0]};
    end
    return e;
  endfunction

  task automatic send(input logic [23:0] tag, input logic kn, input logic oam, input logic [1:0] p,
                      input logic [11:0] vpi, input logic [15:0] vci, input logic [15:0] w0,
                      input logic [15:0] w1, input logic [15:0] w2, input logic lm);
    exp_t e;
    @(negedge clk);
    in_valid = 1; in_known = kn; in_oam = oam; in_port = p; in_vpi = vpi; in_vci = vci;
    ent_w0 = w0; ent_w1 = w1; ent_w2 = w2; long_mode = lm;
    e = model(kn, oam, p, vpi, vci, w0, w1, w2, lm, unk_norm_map, unk_oam_map);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      ent_w0 = 16'hFFFF; ent_w1 = 16'hFFFF; ent_w2 = 16'hFFFF;
    end
  endtask

  task automatic chk(input logic [23:0] tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk("R1 ", "out_valid", 64'(out_valid), 64'd1);
        chk(e.tag, "dest", 64'(out_dest), 64'(e.dest));
        chk(e.tag, "header", {28'd0, out_vpi, out_vci, out_xlated}, {28'd0, e.vpi, e.vci, e.xl});
        chk(e.tag, "crv", 64'({out_crv_a, out_crv_b}), 64'({e.a, e.b}));
      end else begin
        chk("R1 ", "idle valid", 64'(out_valid), 64'd0);
        chk("R8 ", "idle crv", 64'({out_crv_a, out_crv_b}), 64'd0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ", "reset state", {57'd0, out_valid, out_dest, out_crv_a, out_crv_b},
        64'd0);
    unk_norm_map = 12'h5A3;
    unk_oam_map  = 12'hC69;
    rst_n = 1;
    idle(2);
    // R2 user cells
    send("R2 ", 1, 0, 0, 12'h123, 16'h4567, 16'h0015, 16'h0, 16'h0, 0);
    send("R2 ", 1, 0, 1, 12'h001, 16'h0020, 16'h01E0, 16'h0, 16'h0, 0);
    send("R2 ", 1, 0, 2, 12'hFFF, 16'hFFFF, 16'h001F, 16'h0, 16'h0, 1);
    // R3 OAM cells with a full user mask
    send("R3 ", 1, 1, 0, 12'h0AB, 16'h0004, 16'h015F, 16'h0, 16'h0, 0);
    send("R3 ", 1, 1, 2, 12'h0AB, 16'h0005, 16'h001F, 16'h0, 16'h0, 1);
    idle(1);
    // R4 unknown cells on every port code, entry words hostile
    for (int p = 0; p < 4; p++) begin
      send("R4 ", 0, 0, 2'(p), 12'h3C3, 16'hBEEF, 16'hFFFF, 16'h0ABC, 16'h1234, 1);
      send("R4 ", 0, 1, 2'(p), 12'h3C3, 16'hBEEF, 16'hFFFF, 16'h0ABC, 16'h1234, 1);
    end
    // R5 each replace flag alone, then all
    send("R5 ", 1, 0, 0, 12'h123, 16'h4567, 16'h2003, 16'h0ABC, 16'hD00D, 1);
    send("R5 ", 1, 0, 0, 12'h123, 16'h4567, 16'h4003, 16'h0ABC, 16'hD00D, 1);
    send("R5 ", 1, 1, 1, 12'h123, 16'h4567, 16'h8020, 16'h0ABC, 16'hD00D, 1);
    send("R5 ", 1, 0, 2, 12'h123, 16'h4567, 16'hE004, 16'h0ABC, 16'hD00D, 1);
    // R6 same flags in short mode
    send("R6 ", 1, 0, 0, 12'h123, 16'h4567, 16'hE01F, 16'h0ABC, 16'hD00D, 0);
    // R7 rewrite with SAR bit set
    send("R7 ", 1, 0, 1, 12'h055, 16'h0101, 16'h801F, 16'h0000, 16'h7777, 1);
    send("R7 ", 1, 0, 1, 12'h055, 16'h0101, 16'h2010, 16'h0F00, 16'h7777, 1);
    idle(1);
    // R8 clock-recovery tags
    send("R8 ", 1, 0, 0, 12'h010, 16'h0030, 16'h0201, 16'h0, 16'h0, 0);
    send("R8 ", 1, 1, 0, 12'h011, 16'h0031, 16'h0420, 16'h0, 16'h0, 0);
    send("R8 ", 1, 0, 1, 12'h012, 16'h0032, 16'h0600, 16'h0, 16'h0, 1);
    idle(2);
    // R9 long mode, no flags, garbage extra words
    send("R9 ", 1, 0, 2, 12'h9A5, 16'h5AA5, 16'h1F1F, 16'hFFFF, 16'hFFFF, 1);
    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule